// File: doc/BRIEF.md
# Partition-Bounded Comparand Rotator

This block holds a 128-bit comparand word. It can load the word, present it, and rotate it by one bit position per strobe. The rotate does not wrap over the whole word. It wraps only over the content-matching (CAM) field. A 3-bit partition code chooses that field, and the field always starts and ends on a 32-bit boundary. The rest of the word is the associated-data (RAM) field, and a rotate never changes it. The RAM field can sit at the low end or the high end of the word.

Control logic that issues instructions drives the load and rotate strobes and the partition code. The block returns the register contents on a single output bus, one clock edge after each command.

Partition codes:

| Code | CAM field |
|------|-----------|
| 000 | bits 127..0 |
| 001 | bits 127..32 |
| 010 | bits 127..64 |
| 011 | bits 127..96 |
| 100 | bits 95..0 |
| 101 | bits 63..0 |
| 110 | bits 31..0 |
| 111 | bits 127..0 |

Top module: `cmp_rotator`

## Requirements
- R1: While reset (rstN low) is active, the register is cleared to all zeros, and it stays zero until the first command.
- R2: When loadEn is high at a rising edge, cmpValue equals loadData after that edge.
- R3: A load takes priority over a rotate requested in the same cycle. The register takes loadData unrotated.
- R4: When rotRight and rotLeft are both high without a load, the register keeps its value.
- R5: A right rotate moves each CAM bit one position down. The bit at the CAM field's lowest position moves to its highest position.
- R6: A left rotate moves each CAM bit one position up. The bit at the CAM field's highest position moves to its lowest position.
- R7: During any rotate, every bit outside the CAM field keeps its value.
- R8: Codes 000 and 111 make all 128 bits CAM, so the rotate wraps between bit 0 and bit 127.
- R9: Codes 001, 010 and 011 place a RAM field of 32, 64 or 96 bits at the low end. The CAM field is then bits 127..32, 127..64 or 127..96.
- R10: Codes 100, 101 and 110 place a RAM field of 32, 64 or 96 bits at the high end. The CAM field is then bits 95..0, 63..0 or 31..0.
- R11: With no strobe asserted, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| loadEn | input | 1 | Load strobe |
| loadData | input | 128 | Word to load |
| rotRight | input | 1 | Rotate-right strobe |
| rotLeft | input | 1 | Rotate-left strobe |
| partCode | input | 3 | CAM/RAM partition code |
| cmpValue | output | 128 | Current register contents |

## Verification
Every command has its result on cmpValue after the first rising edge at which its strobe is sampled. There is one register stage and no further latency. The bench changes inputs on the falling edge and reads cmpValue 1 ns after the next rising edge, so each check sees exactly one command's effect. It then drops the strobes before the following edge. The bench works out each expected word from its own list of CAM bounds per partition code. Dedicated single-bit cases pin down the wrap at each end of the field for low, high and full partitions.

// File: rtl/cmp_rotator_pkg.sv
`timescale 1ns/1ps
package cmp_rotator_pkg;
  // strobes passed from control to datapath; at most one is set
  typedef struct packed {
    logic doLoad;
    logic doRotRight;
    logic doRotLeft;
  } rotCmd_t;
endpackage

// File: rtl/cmp_rotator_ctrl.sv
`timescale 1ns/1ps
module cmp_rotator_ctrl
  import cmp_rotator_pkg::*;
(
  input  logic    loadEn,
  input  logic    rotRight,
  input  logic    rotLeft,
  output rotCmd_t cmd
);
  always_comb begin
    cmd.doLoad     = loadEn;
    // opposing rotates cancel; a load masks both
    cmd.doRotRight = rotRight & ~rotLeft & ~loadEn;
    cmd.doRotLeft  = rotLeft & ~rotRight & ~loadEn;
  end
endmodule

// File: rtl/cmp_rotator_dp.sv
`timescale 1ns/1ps
module cmp_rotator_dp
  import cmp_rotator_pkg::*;
#(
  parameter int WIDTH  = 128,
  parameter int SEG    = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rotCmd_t           cmd,
  input  logic [WIDTH-1:0]  loadData,
  input  logic [CODE_W-1:0] partCode,
  output logic [WIDTH-1:0]  q
);
  localparam int NSEG  = WIDTH / SEG;
  localparam int IDX_W = $clog2(WIDTH);

  logic [IDX_W-1:0] loIdx, hiIdx;
  logic [WIDTH-1:0] rightNext, leftNext;

  // field bounds from the partition code
  always_comb begin
    int c;
    c = int'(partCode);
    loIdx = '0;
    hiIdx = IDX_W'(WIDTH - 1);
    if (c >= 1 && c <= NSEG - 1) begin
      loIdx = IDX_W'(c * SEG);
    end else if (c >= NSEG && c <= 2 * NSEG - 2) begin
      hiIdx = IDX_W'(WIDTH - 1 - (c - NSEG + 1) * SEG);
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic inCam;
    assign inCam = (IDX_W'(i) >= loIdx) && (IDX_W'(i) <= hiIdx);
    if (i == WIDTH - 1) begin : g_top
      assign rightNext[i] = (inCam && IDX_W'(i) == hiIdx) ? q[loIdx] : q[i];
    end else begin : g_mid
      assign rightNext[i] = !inCam ? q[i] :
                            (IDX_W'(i) == hiIdx) ? q[loIdx] : q[i+1];
    end
    if (i == 0) begin : g_bot
      assign leftNext[i] = (inCam && IDX_W'(i) == loIdx) ? q[hiIdx] : q[i];
    end else begin : g_low
      assign leftNext[i] = !inCam ? q[i] :
                           (IDX_W'(i) == loIdx) ? q[hiIdx] : q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               q <= '0;
    else if (cmd.doLoad)     q <= loadData;
    else if (cmd.doRotRight) q <= rightNext;
    else if (cmd.doRotLeft)  q <= leftNext;
  end
endmodule

// File: rtl/cmp_rotator.sv
`timescale 1ns/1ps
module cmp_rotator
  import cmp_rotator_pkg::*;
#(
  parameter int WIDTH  = 128,
  parameter int SEG    = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [WIDTH-1:0]  loadData,
  input  logic              rotRight,
  input  logic              rotLeft,
  input  logic [CODE_W-1:0] partCode,
  output logic [WIDTH-1:0]  cmpValue
);
  rotCmd_t cmd;

  cmp_rotator_ctrl u_ctrl (
    .loadEn   (loadEn),
    .rotRight (rotRight),
    .rotLeft  (rotLeft),
    .cmd      (cmd)
  );

  cmp_rotator_dp #(.WIDTH(WIDTH), .SEG(SEG), .CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .loadData (loadData),
    .partCode (partCode),
    .q        (cmpValue)
  );
endmodule

// File: rtl/cmp_rotator_chk.sv
`timescale 1ns/1ps
module cmp_rotator_chk #(
  parameter int WIDTH  = 128,
  parameter int SEG    = 32,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [WIDTH-1:0]  loadData,
  input logic              rotRight,
  input logic              rotLeft,
  input logic [CODE_W-1:0] partCode,
  input logic [WIDTH-1:0]  cmpValue
);
  localparam int NSEG = WIDTH / SEG;

  // bits that a rotate must leave alone, built segment by segment
  logic [WIDTH-1:0] ramMask;
  always_comb begin
    int c;
    c = int'(partCode);
    ramMask = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (c >= 1 && c <= NSEG - 1 && s < c)
        ramMask[s*SEG +: SEG] = '1;
      if (c >= NSEG && c <= 2 * NSEG - 2 && s >= 2 * NSEG - 1 - c)
        ramMask[s*SEG +: SEG] = '1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> cmpValue == '0);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> cmpValue == $past(loadData));

  a_r3_load_over_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && (rotRight || rotLeft)) |=> cmpValue == $past(loadData));

  a_r4_both_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && rotRight && rotLeft) |=> $stable(cmpValue));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !rotRight && !rotLeft) |=> $stable(cmpValue));

  a_r7_ram_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && (rotRight ^ rotLeft)) |=>
      (cmpValue & $past(ramMask)) == ($past(cmpValue) & $past(ramMask)));

  a_r5_ones_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && (rotRight ^ rotLeft)) |=>
      $countones(cmpValue) == $countones($past(cmpValue)));
endmodule

bind cmp_rotator cmp_rotator_chk #(.WIDTH(WIDTH), .SEG(SEG), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadEn   (loadEn),
  .loadData (loadData),
  .rotRight (rotRight),
  .rotLeft  (rotLeft),
  .partCode (partCode),
  .cmpValue (cmpValue)
);

// File: tb/cmp_rotator_bench.sv
`timescale 1ns/1ps
module cmp_rotator_bench;
  logic         clk = 1'b0;
  logic         rstN;
  logic         loadEn;
  logic [127:0] loadData;
  logic         rotRight;
  logic         rotLeft;
  logic [2:0]   partCode;
  logic [127:0] cmpValue;

  int nChecks = 0;
  int nFails  = 0;
  logic [127:0] expVal;

  always #4 clk = ~clk;   // 125 MHz

  cmp_rotator u_cmp_rotator (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .rotRight(rotRight), .rotLeft(rotLeft), .partCode(partCode),
    .cmpValue(cmpValue)
  );

  localparam logic [127:0] PAT_A = 128'hDEADBEEF_0123_4567_89AB_CDEF_F00D_CAFE;
  localparam logic [127:0] PAT_B = 128'h8000_0001_5A5A_A5A5_1234_5678_0F0F_F0F1;

  function automatic void bounds(input logic [2:0] c, output int lo, output int hi);
    case (c)
      3'b001:  begin lo = 32; hi = 127; end
      3'b010:  begin lo = 64; hi = 127; end
      3'b011:  begin lo = 96; hi = 127; end
      3'b100:  begin lo = 0;  hi = 95;  end
      3'b101:  begin lo = 0;  hi = 63;  end
      3'b110:  begin lo = 0;  hi = 31;  end
      default: begin lo = 0;  hi = 127; end
    endcase
  endfunction

  function automatic logic [127:0] modelRot(input logic [127:0] v, input logic [2:0] c,
                                            input bit toRight);
    int lo, hi;
    logic [127:0] r;
    bounds(c, lo, hi);
    r = v;
    if (toRight) begin
      for (int i = lo; i < hi; i++) r[i] = v[i+1];
      r[hi] = v[lo];
    end else begin
      for (int i = lo + 1; i <= hi; i++) r[i] = v[i-1];
      r[lo] = v[hi];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply one cycle of strobes, sample just after the edge, then release
  task automatic step(input logic ld, input logic [127:0] d, input logic rr,
                      input logic rl, input logic [2:0] c);
    @(negedge clk);
    loadEn = ld; loadData = d; rotRight = rr; rotLeft = rl; partCode = c;
    @(posedge clk);
    #1;
    loadEn = 1'b0; rotRight = 1'b0; rotLeft = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset clears", cmpValue, '0);
    step(1'b0, PAT_A, 1'b0, 1'b0, 3'b000);
    check("R1 stays zero when idle", cmpValue, '0);
  endtask

  task automatic t_load();
    step(1'b1, PAT_A, 1'b0, 1'b0, 3'b000);
    check("R2 load", cmpValue, PAT_A);
    step(1'b1, PAT_B, 1'b0, 1'b0, 3'b101);
    check("R2 second load", cmpValue, PAT_B);
  endtask

  task automatic t_idle();
    step(1'b0, PAT_A, 1'b0, 1'b0, 3'b010);
    check("R11 idle hold", cmpValue, PAT_B);
  endtask

  task automatic t_loadWins();
    step(1'b1, PAT_A, 1'b1, 1'b0, 3'b000);
    check("R3 load beats right rotate", cmpValue, PAT_A);
    step(1'b1, PAT_B, 1'b0, 1'b1, 3'b001);
    check("R3 load beats left rotate", cmpValue, PAT_B);
  endtask

  task automatic t_bothHold();
    step(1'b0, PAT_A, 1'b1, 1'b1, 3'b000);
    check("R4 both rotates hold", cmpValue, PAT_B);
  endtask

  task automatic t_allCodes();
    for (int c = 0; c < 8; c++) begin
      string tag;
      if (c == 0 || c == 7) tag = "R8";
      else if (c < 4)       tag = "R9";
      else                  tag = "R10";
      step(1'b1, PAT_A, 1'b0, 1'b0, 3'(c));
      expVal = modelRot(PAT_A, 3'(c), 1'b1);
      step(1'b0, '0, 1'b1, 1'b0, 3'(c));
      check($sformatf("R5 %s right code %0d", tag, c), cmpValue, expVal);
      expVal = modelRot(expVal, 3'(c), 1'b0);
      expVal = modelRot(expVal, 3'(c), 1'b0);
      step(1'b0, '0, 1'b0, 1'b1, 3'(c));
      step(1'b0, '0, 1'b0, 1'b1, 3'(c));
      check($sformatf("R6 %s left x2 code %0d", tag, c), cmpValue, expVal);
    end
  endtask

  task automatic t_wrapEdges();
    step(1'b1, 128'h1 << 32, 1'b0, 1'b0, 3'b001);
    step(1'b0, '0, 1'b1, 1'b0, 3'b001);
    check("R5 R9 low-RAM right wrap to bit127", cmpValue, 128'h1 << 127);
    step(1'b1, 128'h1 << 95, 1'b0, 1'b0, 3'b100);
    step(1'b0, '0, 1'b0, 1'b1, 3'b100);
    check("R6 R10 high-RAM left wrap to bit0", cmpValue, 128'h1);
    step(1'b1, 128'h1 << 127, 1'b0, 1'b0, 3'b111);
    step(1'b0, '0, 1'b0, 1'b1, 3'b111);
    check("R6 R8 code 111 full left wrap", cmpValue, 128'h1);
    step(1'b0, '0, 1'b1, 1'b0, 3'b000);
    check("R5 R8 code 000 full right wrap", cmpValue, 128'h1 << 127);
    step(1'b1, 128'h1, 1'b0, 1'b0, 3'b110);
    step(1'b0, '0, 1'b1, 1'b0, 3'b110);
    check("R5 R10 code 110 right wrap to bit31", cmpValue, 128'h1 << 31);
  endtask

  task automatic t_ramKept();
    step(1'b1, PAT_B, 1'b0, 1'b0, 3'b010);
    for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b1, 1'b0, 3'b010);
    check("R7 low RAM field kept", {64'h0, cmpValue[63:0]}, {64'h0, PAT_B[63:0]});
    step(1'b1, PAT_A, 1'b0, 1'b0, 3'b101);
    for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, 1'b1, 3'b101);
    check("R7 high RAM field kept", {cmpValue[127:64], 64'h0}, {PAT_A[127:64], 64'h0});
  endtask

  initial begin
    #1600000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; loadEn = 1'b0; loadData = '0;
    rotRight = 1'b0; rotLeft = 1'b0; partCode = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_load();
    t_idle();
    t_loadWins();
    t_bothHold();
    t_allCodes();
    t_wrapEdges();
    t_ramKept();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule